// File: doc/BRIEF.md
# Dual-Bank Non-Volatile Memory Request Arbiter

This block sequences every access a bus master makes to a two-bank non-volatile memory. Each request carries a kind (data read, instruction fetch, write/erase or option-byte load), a target bank, a protection bit and, for writes, a flag saying whether the word belongs to a half-page burst. The block then decides what happens to the request. It can be served at once, held behind the operation in progress, filtered out as protected, aborted as a rule violation, or refused with a hard-fault pulse.

Cell programming is not modelled in detail. A program operation occupies the memory for a fixed number of cycles, and so do an abort recovery and an option-byte load. While a request is held, the master sees a stall and must present no new request. Three sticky error flags record protected writes, rule violations and protected reads. A down-counting output reports how many words an open half-page burst still lacks.

Top module: `nvm_arbiter`

## Requirements
- R1: A write/erase (`req_kind`=2) with `req_prot`=1 never starts a memory operation and sets `err_flags[0]`.
- R2: Each error flag stays set until a one on the matching `err_clr` bit. A set and a clear in the same cycle leave the flag set.
- R3: An unprotected single-word write (`req_half`=0) to an idle block keeps `busy` high for exactly PROG_CYC cycles, counted from the accepting edge.
- R4: An unprotected write that arrives while an operation runs raises `stall`. It starts as soon as that operation ends, so `busy` stays high with no gap for the sum of both durations.
- R5: The first half-page word (`req_half`=1) opens a burst and each further word to the same bank lowers `words_left` by one. When HALF_WORDS words have arrived, `words_left` returns to 0 and programming starts.
- R6: During a burst, a word to the other bank or a single-word write is a rule violation. It sets `err_flags[1]`, closes the burst and keeps `busy` high for exactly ABORT_CYC cycles.
- R7: An unprotected data read (`req_kind`=0) during an incomplete burst gives a one-cycle `hard_fault` pulse, is not served, and leaves `words_left` unchanged.
- R8: An unprotected instruction fetch (`req_kind`=1) during an incomplete burst drops the burst without any error and is served at once from either bank (`grant`=1, `words_left`=0, `busy`=0).
- R9: While a program operation runs, a read to the same bank is held with `stall` high. It is granted (`grant`, `grant_bank`) on the cycle the operation ends, and `stall` falls on that same cycle. A read to the other bank is granted on the cycle after it is accepted.
- R10: A read with `req_prot`=1 is never granted and sets `err_flags[2]`. An ongoing write keeps running.
- R11: An option-byte load (`req_kind`=3) to an idle block raises `obl_active` at once, for exactly OBL_CYC cycles.
- R12: An option-byte load that arrives during a write waits and starts on the cycle that write ends. While it is pending or active, an unprotected write is refused with `err_flags[1]` and never runs.
- R13: A request presented while `stall` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_kind | input | 2 | 0 read, 1 fetch, 2 write/erase, 3 option-byte load |
| req_bank | input | 1 | Target bank |
| req_prot | input | 1 | Target address is protected |
| req_half | input | 1 | Write word belongs to a half-page burst |
| err_clr | input | 3 | Write-one-to-clear strobes for the error flags |
| stall | output | 1 | Master blocked by a held request |
| busy | output | 1 | Memory interface occupied (burst, program, abort or load) |
| grant | output | 1 | One-cycle pulse: a read or fetch is served |
| grant_bank | output | 1 | Bank of the served read or fetch |
| hard_fault | output | 1 | One-cycle fault pulse |
| err_flags | output | 3 | Sticky: [0] protected write, [1] rule violation, [2] protected read |
| obl_active | output | 1 | Option-byte load running |
| words_left | output | CW | Words still missing from an open burst |

## Verification
The bench builds the block with a four-word half page, three program cycles and two cycles each for abort and option-byte load. At these values every word position of a burst is swept, every pairing of write bank and read bank is covered, and every overlap of a pending load with a finishing write fits in a few cycles. Durations are counted at the ports and compared with the parameter values. The same short windows also let the race between an arriving request and the end of an operation be driven on exact cycles.

// File: rtl/nvm_arb_pkg.sv
package nvm_arb_pkg;

    typedef enum logic [1:0] {
        K_READ  = 2'd0,
        K_FETCH = 2'd1,
        K_WRITE = 2'd2,
        K_OBL   = 2'd3
    } req_kind_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_BURST,
        S_PROG,
        S_ABORT,
        S_OBL
    } arb_state_e;

    typedef struct packed {
        logic bank;
        logic half;
    } wr_req_t;

    localparam int ERR_WRPROT = 0;
    localparam int ERR_RULE   = 1;
    localparam int ERR_RDPROT = 2;
    localparam int N_ERR      = 3;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/nvm_busy_timer.sv
module nvm_busy_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/nvm_sticky_flags.sv
module nvm_sticky_flags #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    output logic [N-1:0] flags
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        logic f_q;
        always_ff @(posedge clk) begin
            if (rst)
                f_q <= 1'b0;
            else if (set[i])
                f_q <= 1'b1;
            else if (clr[i])
                f_q <= 1'b0;
        end
        assign flags[i] = f_q;
    end
endmodule

// File: rtl/nvm_arbiter.sv
module nvm_arbiter
    import nvm_arb_pkg::*;
#(
    parameter int HALF_WORDS = 16,
    parameter int PROG_CYC   = 8,
    parameter int ABORT_CYC  = 4,
    parameter int OBL_CYC    = 6,
    localparam int CW = $clog2(HALF_WORDS + 1),
    localparam int TW = $clog2(max3(PROG_CYC, ABORT_CYC, OBL_CYC) + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    input  logic [1:0]    req_kind,
    input  logic          req_bank,
    input  logic          req_prot,
    input  logic          req_half,
    input  logic [2:0]    err_clr,
    output logic          stall,
    output logic          busy,
    output logic          grant,
    output logic          grant_bank,
    output logic          hard_fault,
    output logic [2:0]    err_flags,
    output logic          obl_active,
    output logic [CW-1:0] words_left
);
    arb_state_e state_q, state_d;
    logic [CW-1:0] wcnt_q, wcnt_d;
    logic bank_q, bank_d;
    logic rd_held_q, rd_held_d, rd_bank_q, rd_bank_d;
    logic wr_held_q, wr_held_d;
    wr_req_t wr_q, wr_d;
    logic obl_pend_q, obl_pend_d;
    logic grant_q, grant_d, gbank_q, gbank_d, hf_q, hf_d;
    logic [N_ERR-1:0] err_set;
    logic t_load, t_zero;
    logic [TW-1:0] t_val;
    logic accept, done, timed;
    req_kind_e kind;

    assign kind   = req_kind_e'(req_kind);
    assign stall  = rd_held_q | wr_held_q;
    assign accept = req_valid & ~stall;
    assign timed  = (state_q == S_PROG) || (state_q == S_ABORT) || (state_q == S_OBL);
    assign done   = timed & t_zero;

    nvm_busy_timer #(.W(TW)) u_timer (
        .clk(clk), .rst(rst), .load(t_load), .load_val(t_val), .zero(t_zero)
    );

    nvm_sticky_flags #(.N(N_ERR)) u_flags (
        .clk(clk), .rst(rst), .set(err_set), .clr(err_clr), .flags(err_flags)
    );

    always_comb begin
        state_d    = state_q;
        wcnt_d     = wcnt_q;
        bank_d     = bank_q;
        rd_held_d  = rd_held_q;
        rd_bank_d  = rd_bank_q;
        wr_held_d  = wr_held_q;
        wr_d       = wr_q;
        obl_pend_d = obl_pend_q;
        grant_d    = 1'b0;
        gbank_d    = gbank_q;
        hf_d       = 1'b0;
        err_set    = '0;
        t_load     = 1'b0;
        t_val      = TW'(PROG_CYC - 1);

        // End of a timed operation: release held read, then pick next work
        if (done) begin
            state_d = S_IDLE;
            wcnt_d  = '0;
            if (rd_held_q) begin
                grant_d   = 1'b1;
                gbank_d   = rd_bank_q;
                rd_held_d = 1'b0;
            end
            if (obl_pend_q) begin
                state_d    = S_OBL;
                obl_pend_d = 1'b0;
                t_load     = 1'b1;
                t_val      = TW'(OBL_CYC - 1);
            end else if (wr_held_q) begin
                wr_held_d = 1'b0;
                bank_d    = wr_q.bank;
                if (wr_q.half && HALF_WORDS > 1) begin
                    state_d = S_BURST;
                    wcnt_d  = CW'(1);
                end else begin
                    state_d = S_PROG;
                    t_load  = 1'b1;
                end
            end
        end

        if (accept) begin
            unique case (kind)
                K_READ, K_FETCH: begin
                    if (req_prot) begin
                        err_set[ERR_RDPROT] = 1'b1;
                    end else if (state_q == S_BURST) begin
                        if (kind == K_READ) begin
                            hf_d = 1'b1;
                        end else begin
                            grant_d = 1'b1;
                            gbank_d = req_bank;
                            wcnt_d  = '0;
                            if (obl_pend_q) begin
                                state_d    = S_OBL;
                                obl_pend_d = 1'b0;
                                t_load     = 1'b1;
                                t_val      = TW'(OBL_CYC - 1);
                            end else begin
                                state_d = S_IDLE;
                            end
                        end
                    end else if ((state_q == S_PROG || state_q == S_ABORT) &&
                                 !done && req_bank == bank_q) begin
                        rd_held_d = 1'b1;
                        rd_bank_d = req_bank;
                    end else begin
                        grant_d = 1'b1;
                        gbank_d = req_bank;
                    end
                end
                K_WRITE: begin
                    if (req_prot) begin
                        err_set[ERR_WRPROT] = 1'b1;
                    end else if (obl_pend_q || state_q == S_OBL) begin
                        err_set[ERR_RULE] = 1'b1;
                    end else if (state_q == S_BURST) begin
                        if (req_half && req_bank == bank_q) begin
                            wcnt_d = wcnt_q + 1'b1;
                            if (wcnt_q + 1'b1 == CW'(HALF_WORDS)) begin
                                state_d = S_PROG;
                                wcnt_d  = '0;
                                t_load  = 1'b1;
                            end
                        end else begin
                            err_set[ERR_RULE] = 1'b1;
                            state_d = S_ABORT;
                            wcnt_d  = '0;
                            t_load  = 1'b1;
                            t_val   = TW'(ABORT_CYC - 1);
                        end
                    end else if (state_q == S_IDLE || done) begin
                        bank_d = req_bank;
                        if (req_half && HALF_WORDS > 1) begin
                            state_d = S_BURST;
                            wcnt_d  = CW'(1);
                        end else begin
                            state_d = S_PROG;
                            t_load  = 1'b1;
                        end
                    end else begin
                        wr_held_d = 1'b1;
                        wr_d      = '{bank: req_bank, half: req_half};
                    end
                end
                K_OBL: begin
                    if (state_q == S_IDLE || done) begin
                        state_d    = S_OBL;
                        obl_pend_d = 1'b0;
                        t_load     = 1'b1;
                        t_val      = TW'(OBL_CYC - 1);
                    end else begin
                        obl_pend_d = 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= S_IDLE;
            wcnt_q     <= '0;
            bank_q     <= 1'b0;
            rd_held_q  <= 1'b0;
            rd_bank_q  <= 1'b0;
            wr_held_q  <= 1'b0;
            wr_q       <= '0;
            obl_pend_q <= 1'b0;
            grant_q    <= 1'b0;
            gbank_q    <= 1'b0;
            hf_q       <= 1'b0;
        end else begin
            state_q    <= state_d;
            wcnt_q     <= wcnt_d;
            bank_q     <= bank_d;
            rd_held_q  <= rd_held_d;
            rd_bank_q  <= rd_bank_d;
            wr_held_q  <= wr_held_d;
            wr_q       <= wr_d;
            obl_pend_q <= obl_pend_d;
            grant_q    <= grant_d;
            gbank_q    <= gbank_d;
            hf_q       <= hf_d;
        end
    end

    assign busy       = (state_q != S_IDLE);
    assign obl_active = (state_q == S_OBL);
    assign grant      = grant_q;
    assign grant_bank = gbank_q;
    assign hard_fault = hf_q;
    assign words_left = (state_q == S_BURST) ? CW'(HALF_WORDS) - wcnt_q : '0;
endmodule

// File: rtl/nvm_arbiter_chk.sv
module nvm_arbiter_chk #(
    parameter int CW = 5
) (
    input logic          clk,
    input logic          rst,
    input logic          req_valid,
    input logic [1:0]    req_kind,
    input logic          req_prot,
    input logic [2:0]    err_clr,
    input logic          stall,
    input logic          busy,
    input logic          grant,
    input logic          hard_fault,
    input logic [2:0]    err_flags,
    input logic          obl_active,
    input logic [CW-1:0] words_left
);
    logic acc;
    assign acc = req_valid & ~stall;

    p_wrprot_flag_r1: assert property (@(posedge clk) disable iff (rst)
        (acc && req_kind == 2'd2 && req_prot) |=> err_flags[0]);

    p_sticky_r2: assert property (@(posedge clk) disable iff (rst)
        (err_flags[2] && !err_clr[2]) |=> err_flags[2]);

    p_quiet_burst_r5: assert property (@(posedge clk) disable iff (rst)
        (words_left != '0 && !acc) |=> (words_left == $past(words_left)));

    p_fault_source_r7: assert property (@(posedge clk) disable iff (rst)
        hard_fault |-> $past(req_valid && req_kind == 2'd0 && !req_prot));

    p_fetch_drop_r8: assert property (@(posedge clk) disable iff (rst)
        (acc && req_kind == 2'd1 && !req_prot && words_left != '0)
        |=> (grant && words_left == '0));

    p_stall_busy_r9: assert property (@(posedge clk) disable iff (rst)
        stall |-> busy);

    p_obl_refuse_r12: assert property (@(posedge clk) disable iff (rst)
        (obl_active && acc && req_kind == 2'd2 && !req_prot) |=> err_flags[1]);

    p_stall_ignore_r13: assert property (@(posedge clk) disable iff (rst)
        (stall && req_valid && req_kind == 2'd2 && req_prot && !err_flags[0])
        |=> !err_flags[0]);
endmodule

bind nvm_arbiter nvm_arbiter_chk #(.CW(CW)) u_chk (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
    .req_prot(req_prot), .err_clr(err_clr), .stall(stall), .busy(busy),
    .grant(grant), .hard_fault(hard_fault), .err_flags(err_flags),
    .obl_active(obl_active), .words_left(words_left)
);

// File: tb/nvm_arbiter_tb.sv
module nvm_arbiter_tb;
    localparam int CLK_PERIOD = 10;
    localparam int HW  = 4;
    localparam int PC  = 3;
    localparam int AC  = 2;
    localparam int OC  = 2;
    localparam int CW  = $clog2(HW + 1);

    logic clk = 1'b0, rst = 1'b1;
    logic req_valid = 1'b0, req_bank = 1'b0, req_prot = 1'b0, req_half = 1'b0;
    logic [1:0] req_kind = 2'd0;
    logic [2:0] err_clr = 3'b000;
    logic stall, busy, grant, grant_bank, hard_fault, obl_active;
    logic [2:0] err_flags;
    logic [CW-1:0] words_left;

    int tests = 0, fails = 0, cycles = 0;

    nvm_arbiter #(.HALF_WORDS(HW), .PROG_CYC(PC), .ABORT_CYC(AC), .OBL_CYC(OC)) u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
        .req_bank(req_bank), .req_prot(req_prot), .req_half(req_half),
        .err_clr(err_clr), .stall(stall), .busy(busy), .grant(grant),
        .grant_bank(grant_bank), .hard_fault(hard_fault), .err_flags(err_flags),
        .obl_active(obl_active), .words_left(words_left)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            tests++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
            summary();
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic send(input int kind, input bit bank, input bit prot, input bit half);
        @(negedge clk);
        req_valid = 1'b1; req_kind = kind[1:0];
        req_bank = bank; req_prot = prot; req_half = half;
        @(posedge clk); #1;
        req_valid = 1'b0;
    endtask

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic wait_idle();
        while (busy) step();
    endtask

    task automatic clear_all();
        @(negedge clk); err_clr = 3'b111;
        @(posedge clk); #1; err_clr = 3'b000;
    endtask

    initial begin
        int n;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        // reset state
        chk("R3 reset busy", busy, 0);
        chk("R9 reset stall", stall, 0);
        chk("R2 reset flags", err_flags, 0);
        chk("R5 reset words_left", words_left, 0);

        // R1 protected write filtered
        send(2, 0, 1, 0);
        chk("R1 wrprot flag", err_flags[0], 1);
        chk("R1 no busy", busy, 0);
        // R2 sticky then clear, set beats clear
        step();
        chk("R2 sticky", err_flags[0], 1);
        @(negedge clk); err_clr = 3'b001; req_valid = 1'b1; req_kind = 2'd2; req_prot = 1'b1;
        @(posedge clk); #1; err_clr = 3'b000; req_valid = 1'b0;
        chk("R2 set wins", err_flags[0], 1);
        clear_all();
        chk("R2 cleared", err_flags, 0);

        // R3 single write duration
        send(2, 1, 0, 0);
        n = busy;
        while (1) begin step(); if (!busy) break; n++; end
        chk("R3 prog cycles", n, PC);

        // R4 held write
        send(2, 0, 0, 0);
        n = busy;
        send(2, 1, 0, 0);
        chk("R4 stall on held write", stall, 1);
        n++;
        while (1) begin step(); if (!busy) break; n++; end
        chk("R4 back-to-back cycles", n, 2 * PC);
        chk("R4 stall released", stall, 0);

        // R5 burst counting, both banks
        for (int b = 0; b < 2; b++) begin
            for (int i = 1; i <= HW; i++) begin
                send(2, b[0], 0, 1);
                chk($sformatf("R5 words_left b%0d w%0d", b, i), words_left, HW - i);
            end
            chk("R5 programming after burst", busy, 1);
            wait_idle();
        end

        // R6 rule violation at each burst position
        for (int k = 1; k < HW; k++) begin
            for (int i = 0; i < k; i++) send(2, 0, 0, 1);
            send(2, 1, 0, 1);
            chk("R6 rule flag", err_flags[1], 1);
            chk("R6 burst closed", words_left, 0);
            n = busy;
            while (1) begin step(); if (!busy) break; n++; end
            chk("R6 abort cycles", n, AC);
            clear_all();
        end
        send(2, 0, 0, 1);
        send(2, 0, 0, 0);
        chk("R6 single in burst flag", err_flags[1], 1);
        wait_idle(); clear_all();

        // R7 read during burst faults
        send(2, 1, 0, 1);
        send(0, 0, 0, 0);
        chk("R7 hard_fault pulse", hard_fault, 1);
        chk("R7 not granted", grant, 0);
        chk("R7 words_left kept", words_left, HW - 1);
        step();
        chk("R7 pulse one cycle", hard_fault, 0);
        for (int i = 1; i < HW; i++) send(2, 1, 0, 1);
        wait_idle();

        // R8 fetch during burst, both banks
        for (int b = 0; b < 2; b++) begin
            send(2, 0, 0, 1);
            send(1, b[0], 0, 0);
            chk("R8 fetch granted", grant, 1);
            chk("R8 fetch bank", grant_bank, b);
            chk("R8 burst dropped", words_left, 0);
            chk("R8 idle", busy, 0);
            chk("R8 no error", err_flags, 0);
        end

        // R9 read while program, all bank pairs
        for (int wb = 0; wb < 2; wb++) begin
            for (int rb = 0; rb < 2; rb++) begin
                send(2, wb[0], 0, 0);
                send(0, rb[0], 0, 0);
                if (wb == rb) begin
                    chk("R9 held stall", stall, 1);
                    chk("R9 held no grant", grant, 0);
                    // R13 request during stall ignored
                    @(negedge clk); req_valid = 1'b1; req_kind = 2'd2; req_prot = 1'b1;
                    n = 0;
                    while (1) begin
                        @(posedge clk); #1; n++;
                        if (grant) break;
                    end
                    req_valid = 1'b0;
                    chk("R9 grant when write ends", n, PC - 1);
                    chk("R9 grant bank", grant_bank, rb);
                    chk("R9 stall fell", stall, 0);
                    chk("R13 ignored under stall", err_flags[0], 0);
                end else begin
                    chk("R9 other bank grant", grant, 1);
                    chk("R9 other bank id", grant_bank, rb);
                    chk("R9 other bank no stall", stall, 0);
                end
                wait_idle(); clear_all();
            end
        end

        // R10 protected read during write
        send(2, 0, 0, 0);
        send(0, 0, 1, 0);
        chk("R10 rdprot flag", err_flags[2], 1);
        chk("R10 no grant", grant, 0);
        chk("R10 write continues", busy, 1);
        chk("R10 no stall", stall, 0);
        wait_idle(); clear_all();

        // R11 option-byte load when idle
        send(3, 0, 0, 0);
        n = obl_active;
        while (1) begin step(); if (!obl_active) break; n++; end
        chk("R11 obl cycles", n, OC);
        chk("R11 idle after", busy, 0);

        // R12 load during write, write refused meanwhile
        send(2, 0, 0, 0);
        send(3, 0, 0, 0);
        chk("R12 obl pending", obl_active, 0);
        send(2, 1, 0, 0);
        chk("R12 write refused", err_flags[1], 1);
        chk("R12 refused not held", stall, 0);
        n = 0;
        while (1) begin step(); n++; if (obl_active) break; end
        chk("R12 obl starts at write end", n, PC - 2);
        n = 1;
        while (1) begin step(); if (!obl_active) break; n++; end
        chk("R12 obl length", n, OC);
        chk("R12 refused write never ran", busy, 0);
        clear_all();

        summary();
    end
endmodule